// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Selector

This block joins one upstream open-drain line to one of four downstream open-drain lines, picked by a 2-bit select. Every pad is modelled by two signals. The first is the level the pad currently reads. The second is an output-enable that pulls the line to ground while it is high. The block never drives a line high. External pull-ups raise a line whenever no enable holds it low.

Lows pass in both directions. A low on the upstream line is copied onto the chosen downstream line, and a low on the chosen downstream line is copied back upstream. This two-way path is what a bus with several masters needs. Whichever side goes low first owns the path. The block does not drive that side until the owner lets go.

The forwarded enable stays on for a programmable hold time after the source releases. After that comes a short quiet window in which the block drives nothing. During this window the echo of its own drive clears through the input synchronizers. A two-wire bus multiplexer is built from two instances: one for the clock line and one for the data line.

Top module: `od_line_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output-enable is low. With the select input at 00 at reset, channel 0 is the first channel routed.
- R2: The select value {sel_i[1],sel_i[0]} is read as a binary channel index: 00, 01, 10 and 11 choose channels 0, 1, 2 and 3. A low on up_in_i sets dn_oe_o bit k, where k is the chosen channel. The bit goes high at the 4th rising edge after the low is applied.
- R3: At most one dn_oe_o bit is ever high, and it is always the bit of the latched channel. Every other bit stays 0.
- R4: A low on the chosen downstream input sets up_oe_o at the 4th rising edge. A low on a downstream input that is not chosen sets no output-enable.
- R5: After the driving side releases, the forwarded enable stays high through rising edge HOLD_CYCLES+2 and is low from rising edge HOLD_CYCLES+3, counted from the release. HOLD_CYCLES defaults to 4.
- R6: up_oe_o and any dn_oe_o bit are never high together. A forwarded low is never echoed back to the side that owns the path.
- R7: With both lines high and the path idle, all output-enables are 0.
- R8: The select input is taken only while the path is idle. Changing it during a transfer has no effect until the path returns to idle.
- R9: If the source goes low again before the hold time ends, the forwarded enable stays high with no gap.
- R10: If both sides go low in the same cycle from idle, the upstream side wins. dn_oe_o is driven and up_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_i | input | 2 | Downstream channel index |
| up_in_i | input | 1 | Level read from the upstream pad |
| up_oe_o | output | 1 | Upstream pull-down enable (1 = drive low) |
| dn_in_i | input | 4 | Levels read from the downstream pads, bit k = channel k |
| dn_oe_o | output | 4 | Downstream pull-down enables, bit k = channel k |

## Verification
The assertions assume that every pad follows wired-AND behaviour: a line reads low whenever its own enable or some external device holds it low. They also assume that reset is released synchronously. The bench models each pad as the AND of the block's enable and an external pull-low, so the block always sees its own drive reflected back. Select changes are made either while the path is idle or on purpose in the middle of a transfer. Releases are spaced far enough apart that the hold and quiet windows finish before the next transfer begins, except in the case that tests re-assertion during the hold.

// File: rtl/odsel_pkg.sv
package odsel_pkg;
  // Ownership of the path between the upstream line and the latched channel
  typedef enum logic [1:0] {
    DIR_IDLE   = 2'd0,
    DIR_DOWN   = 2'd1,  // upstream owns, downstream pad is driven
    DIR_UP     = 2'd2,  // downstream owns, upstream pad is driven
    DIR_SETTLE = 2'd3   // nothing driven, waiting for own echo to clear
  } dir_e;
endpackage

// File: rtl/odsel_sync.sv
module odsel_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/odsel_hold.sv
module odsel_hold #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,   // source side currently low and owning the path
  output logic busy_o,     // hold window still running
  output logic drive_o     // request for the forwarded pull-down
);
  localparam int CW = (HOLD_CYCLES < 1) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (active_i) begin
      cnt_en = 1'b1;
      cnt_d  = HOLD_LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o  = (cnt_q != '0);
  assign drive_o = active_i | busy_o;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HOLD_LOAD);

  // R5: a release always opens a hold window of nonzero length
  assert_hold_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active_i) && (HOLD_CYCLES > 0)) |-> busy_o);
endmodule

// File: rtl/odsel_ctrl.sv
module odsel_ctrl
  import odsel_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int SEL_W         = $clog2(NUM_CH),
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_lvl_i,
  input  logic [NUM_CH-1:0] dn_lvl_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              dn_hold_busy_i,
  input  logic              up_hold_busy_i,
  output dir_e              dir_o,
  output logic [SEL_W-1:0]  chan_o,
  output logic              dn_src_low_o,
  output logic              up_src_low_o
);
  localparam int SW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES);

  dir_e             dir_q, dir_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [SW-1:0]    settle_q, settle_d;
  logic             sel_en, settle_en;
  logic             chan_lvl;

  assign chan_lvl = dn_lvl_i[sel_q];

  always_comb begin
    dir_d     = dir_q;
    sel_d     = sel_q;
    settle_d  = settle_q;
    sel_en    = 1'b0;
    settle_en = 1'b0;
    case (dir_q)
      DIR_IDLE: begin
        if (!up_lvl_i) begin
          dir_d = DIR_DOWN;          // upstream wins a tie
        end else if (!chan_lvl) begin
          dir_d = DIR_UP;
        end else begin
          sel_en = 1'b1;
          sel_d  = sel_i;
        end
      end
      DIR_DOWN: begin
        if (up_lvl_i && !dn_hold_busy_i) begin
          dir_d     = DIR_SETTLE;
          settle_en = 1'b1;
          settle_d  = SETTLE_LOAD;
        end
      end
      DIR_UP: begin
        if (chan_lvl && !up_hold_busy_i) begin
          dir_d     = DIR_SETTLE;
          settle_en = 1'b1;
          settle_d  = SETTLE_LOAD;
        end
      end
      DIR_SETTLE: begin
        if (settle_q == '0) begin
          dir_d = DIR_IDLE;
        end else begin
          settle_en = 1'b1;
          settle_d  = settle_q - 1'b1;
        end
      end
      default: dir_d = DIR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= DIR_IDLE;
      sel_q    <= '0;
      settle_q <= '0;
    end else begin
      dir_q <= dir_d;
      if (sel_en)    sel_q    <= sel_d;
      if (settle_en) settle_q <= settle_d;
    end
  end

  assign dir_o        = dir_q;
  assign chan_o       = sel_q;
  assign dn_src_low_o = (dir_q == DIR_DOWN) && !up_lvl_i;
  assign up_src_low_o = (dir_q == DIR_UP) && !chan_lvl;

  // R8: the latched channel cannot move while a transfer is in progress
  assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q != DIR_IDLE) |=> $stable(sel_q));

  // R6: a settle window always ends in idle, never jumps straight to a drive state
  assert_settle_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_SETTLE) |=> (dir_q == DIR_SETTLE || dir_q == DIR_IDLE));
endmodule

// File: rtl/od_line_selector.sv
module od_line_selector
  import odsel_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_CH)-1:0]  sel_i,
  input  logic                       up_in_i,
  output logic                       up_oe_o,
  input  logic [NUM_CH-1:0]          dn_in_i,
  output logic [NUM_CH-1:0]          dn_oe_o
);
  localparam int SEL_W         = $clog2(NUM_CH);
  localparam int PAD_W         = NUM_CH + 1;
  localparam int SETTLE_CYCLES = SYNC_STAGES + 1;

  logic [PAD_W-1:0]  pad_lvl;
  logic              up_lvl;
  logic [NUM_CH-1:0] dn_lvl;
  logic [SEL_W-1:0]  sel_s;
  dir_e              dir;
  logic [SEL_W-1:0]  chan;
  logic              dn_src_low, up_src_low;
  logic              dn_busy, up_busy, dn_drive, up_drive;
  logic [NUM_CH-1:0] dn_oe_d, dn_oe_q;
  logic              up_oe_q;

  // Pads read high when released, so they synchronize from an idle value
  odsel_sync #(.WIDTH(PAD_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d_i({dn_in_i, up_in_i}), .q_o(pad_lvl)
  );
  assign up_lvl = pad_lvl[0];
  assign dn_lvl = pad_lvl[PAD_W-1:1];

  odsel_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sel_i), .q_o(sel_s)
  );

  odsel_ctrl #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .up_lvl_i(up_lvl), .dn_lvl_i(dn_lvl), .sel_i(sel_s),
    .dn_hold_busy_i(dn_busy), .up_hold_busy_i(up_busy),
    .dir_o(dir), .chan_o(chan), .dn_src_low_o(dn_src_low), .up_src_low_o(up_src_low)
  );

  // One hold timer per direction
  odsel_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold_dn (
    .clk(clk), .rst_n(rst_n), .active_i(dn_src_low), .busy_o(dn_busy), .drive_o(dn_drive)
  );
  odsel_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold_up (
    .clk(clk), .rst_n(rst_n), .active_i(up_src_low), .busy_o(up_busy), .drive_o(up_drive)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan_oe
    assign dn_oe_d[k] = dn_drive && (chan == SEL_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_oe_q <= '0;
      up_oe_q <= 1'b0;
    end else begin
      dn_oe_q <= dn_oe_d;
      up_oe_q <= up_drive;
    end
  end

  assign dn_oe_o = dn_oe_q;
  assign up_oe_o = up_oe_q;

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_oe_q));

  assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_oe_q) |-> dn_oe_q[chan]);

  assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_oe_q && (|dn_oe_q)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_IDLE) |=> (!up_oe_q && (dn_oe_q == '0)));
endmodule

// File: tb/test_od_line_selector.sv
`timescale 1ns/1ps
module test_od_line_selector;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       ext_up_low = 1'b0;
  logic [3:0] ext_dn_low = 4'b0000;
  logic       up_in, up_oe;
  logic [3:0] dn_in, dn_oe;

  // Wired-AND pad model: a line reads low if anyone pulls it
  assign up_in = ~(up_oe | ext_up_low);
  assign dn_in = ~(dn_oe | ext_dn_low);

  od_line_selector #(.NUM_CH(4), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) i_od_line_selector (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .up_in_i(up_in), .up_oe_o(up_oe),
    .dn_in_i(dn_in), .dn_oe_o(dn_oe)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned at;
    logic        up;
    logic [3:0]  dn;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int fails  = 0;

  task automatic expect_out(input int d, input logic up, input logic [3:0] dn, input string tag);
    exp_t e;
    e.at = cyc + d; e.up = up; e.dn = dn; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares outputs at negedges against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() != 0 && sb_q[0].at <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (e.at != cyc) begin
          fails++;
          $display("FAIL %s: check missed at cycle %0d (now %0d)", e.tag, e.at, cyc);
        end else if (up_oe !== e.up || dn_oe !== e.dn) begin
          fails++;
          $display("FAIL %s: up_oe=%b dn_oe=%b expected up_oe=%b dn_oe=%b",
                   e.tag, up_oe, dn_oe, e.up, e.dn);
        end
      end
    end
  end

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk);
    sel_i = s;
    repeat (5) @(negedge clk);
  endtask

  task automatic down_pulse(input int ch, input int len, input string tag);
    logic [3:0] oh;
    oh = 4'(1 << ch);
    @(negedge clk);
    ext_up_low = 1'b1;
    expect_out(3, 1'b0, 4'b0000, tag);
    expect_out(4, 1'b0, oh, tag);
    repeat (len) @(negedge clk);
    ext_up_low = 1'b0;
    expect_out(HOLD + 2, 1'b0, oh, {tag, " R5 hold"});
    expect_out(HOLD + 3, 1'b0, 4'b0000, {tag, " R5 release"});
    expect_out(HOLD + 6, 1'b0, 4'b0000, {tag, " R6 no echo"});
    repeat (HOLD + 10) @(negedge clk);
  endtask

  task automatic up_pulse(input int ch, input int len, input string tag);
    @(negedge clk);
    ext_dn_low[ch] = 1'b1;
    expect_out(3, 1'b0, 4'b0000, tag);
    expect_out(4, 1'b1, 4'b0000, tag);
    repeat (len) @(negedge clk);
    ext_dn_low[ch] = 1'b0;
    expect_out(HOLD + 2, 1'b1, 4'b0000, {tag, " R5 hold"});
    expect_out(HOLD + 3, 1'b0, 4'b0000, {tag, " R5 release"});
    expect_out(HOLD + 6, 1'b0, 4'b0000, {tag, " R6 no echo"});
    repeat (HOLD + 10) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none

    // R1: reset state
    repeat (3) @(negedge clk);
    expect_out(1, 1'b0, 4'b0000, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    expect_out(1, 1'b0, 4'b0000, "R1 after release");
    repeat (3) @(negedge clk);
    down_pulse(0, 6, "R1 first channel 0");

    // R1: reset in the middle of a transfer clears the drive
    @(negedge clk);
    ext_up_low = 1'b1;
    expect_out(4, 1'b0, 4'b0001, "R1 pre-reset drive");
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    expect_out(1, 1'b0, 4'b0000, "R1 reset clears drive");
    @(negedge clk);
    ext_up_low = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R3: each select code routes the upstream low to its channel only
    for (int ch = 0; ch < 4; ch++) begin
      set_sel(2'(ch));
      down_pulse(ch, 5 + ch, "R2 route down");
    end

    // R4: downstream low on the chosen channel drives upstream
    for (int ch = 0; ch < 4; ch++) begin
      set_sel(2'(ch));
      up_pulse(ch, 6, "R4 route up");
    end

    // R4: low on an unselected channel is ignored
    set_sel(2'b01);
    @(negedge clk);
    ext_dn_low[2] = 1'b1;
    expect_out(4, 1'b0, 4'b0000, "R4 unselected ignored");
    expect_out(8, 1'b0, 4'b0000, "R4 unselected ignored late");
    repeat (10) @(negedge clk);
    ext_dn_low[2] = 1'b0;
    repeat (6) @(negedge clk);
    down_pulse(1, 5, "R4 channel 1 still usable");

    // R8: select change during a transfer waits for idle
    set_sel(2'b00);
    @(negedge clk);
    ext_up_low = 1'b1;
    expect_out(4, 1'b0, 4'b0001, "R8 drive on channel 0");
    repeat (2) @(negedge clk);
    sel_i = 2'b11;
    repeat (6) @(negedge clk);
    ext_up_low = 1'b0;
    expect_out(HOLD + 2, 1'b0, 4'b0001, "R8 channel kept");
    expect_out(HOLD + 3, 1'b0, 4'b0000, "R8 release");
    repeat (HOLD + 10) @(negedge clk);
    down_pulse(3, 5, "R8 new channel after idle");

    // R9: source low again during the hold keeps the drive
    set_sel(2'b10);
    @(negedge clk);
    ext_up_low = 1'b1;
    expect_out(4, 1'b0, 4'b0100, "R9 drive");
    repeat (6) @(negedge clk);
    ext_up_low = 1'b0;
    expect_out(2, 1'b0, 4'b0100, "R9 in hold");
    repeat (3) @(negedge clk);
    ext_up_low = 1'b1;
    expect_out(2, 1'b0, 4'b0100, "R9 no gap");
    expect_out(4, 1'b0, 4'b0100, "R9 past original hold");
    repeat (6) @(negedge clk);
    ext_up_low = 1'b0;
    expect_out(HOLD + 2, 1'b0, 4'b0100, "R9 final hold");
    expect_out(HOLD + 3, 1'b0, 4'b0000, "R9 final release");
    repeat (HOLD + 10) @(negedge clk);

    // R10: simultaneous lows, upstream wins
    set_sel(2'b00);
    @(negedge clk);
    ext_up_low = 1'b1;
    ext_dn_low[0] = 1'b1;
    expect_out(4, 1'b0, 4'b0001, "R10 upstream wins");
    repeat (6) @(negedge clk);
    ext_up_low = 1'b0;
    ext_dn_low[0] = 1'b0;
    expect_out(HOLD + 3, 1'b0, 4'b0000, "R10 release");
    repeat (HOLD + 10) @(negedge clk);

    // R7: idle bus, nothing driven
    @(negedge clk);
    expect_out(1, 1'b0, 4'b0000, "R7 idle");
    expect_out(5, 1'b0, 4'b0000, "R7 idle later");
    repeat (8) @(negedge clk);

    while (sb_q.size() != 0) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule